// File: doc/BRIEF.md
# Self-Timed Byte Store Access Controller

This block sits beside the processor and gives software byte-wide access to a small nonvolatile data store of 512 bytes. The store is modelled as a register array with its own address space. Software reaches it only through four 8-bit I/O slots: two slots hold the byte address, one holds the data byte, and one is a command/status slot. Writing the command slot starts a read or a write. The block holds the processor pipeline stalled for a fixed number of cycles after each start.

A read stalls the CPU for four cycles and leaves the addressed byte in the data slot. A write stalls the CPU for only two cycles. The write then goes on in the background for a parameterised number of cycles, and software polls a busy bit to learn when the next byte may be written. A write start is accepted only when a guard bit was set shortly before it. A start without that guard has no effect. An optional ready interrupt request signals that the store is idle.

The controller is a four-state machine: IDLE, RD_STALL (read stall), WR_STALL (write stall) and WR_BUSY (self-timed write after the stall). The transitions are:
- IDLE to WR_STALL when an armed write start is accepted.
- IDLE to RD_STALL when a read start is accepted.
- RD_STALL to IDLE after four cycles, at which point the data slot is loaded.
- WR_STALL to WR_BUSY after two cycles.
- WR_BUSY to IDLE when the write timer runs out, at which point the byte is committed.

Top module: `nvbyte_ctrl`

## Requirements
- R1: After reset, every slot reads 0x00, `cpu_stall` and `irq_ready` are low, and every byte of the store reads 0xFF.
- R2: Writing command slot (sel 3) with bit 0 set while idle starts a read. `cpu_stall` is high for exactly 4 cycles and command bit 0 reads 1 during them. The data slot (sel 2) then holds the addressed byte, and bit 0 reads 0 again.
- R3: An accepted write start raises `cpu_stall` for exactly 2 cycles.
- R4: Command bit 1 reads 1 for exactly WR_CYCLES cycles from acceptance. It then clears by itself, and the data-slot byte is then stored at the address.
- R5: Command bit 2 arms writes and reads back 1 for 4 cycles. A write start (bit 1) is accepted only on one of the 4 clock edges after the arming edge. The arm bit clears when the window ends and when a write is accepted. A start without arming, or in the same command write as the arming, changes nothing.
- R6: While a read or write is in progress, the following are ignored: writes to the address and data slots, and command bits 0, 1 and 2.
- R7: The address is 9 bits: slot 0 holds bits 7:0 and bit 0 of slot 1 holds bit 8. The upper bits of slot 1 read 0 and never select a byte.
- R8: `irq_ready` is high exactly while the controller is idle and command bit 3 (interrupt enable) is set. Bit 3 stays writable while busy.
- R9: A command write with both bit 0 and bit 1 set while armed starts only the write.
- R10: Slot selects are 0 for address low, 1 for address high, 2 for data and 3 for command. `io_rdata` shows the selected slot in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_sel | input | 2 | Slot select |
| io_we | input | 1 | Slot write strobe |
| io_wdata | input | 8 | Slot write data |
| io_rdata | output | 8 | Selected slot contents |
| cpu_stall | output | 1 | Holds the processor pipeline |
| irq_ready | output | 1 | Ready interrupt request |

## Verification
Two pairs of events can fall in the same cycle, and each pair is provoked on purpose.

The first pair is the end of the arming window and a write start. The bench arms, then waits 0 to 6 cycles before the start. Starts that fall on the fourth edge after arming must be taken, and starts on the fifth must not; the bench judges this by the busy bit and by reading the byte back.

The second pair is the last busy cycle of a write and a fresh arming or read command. The bench issues that command on the very edge where the write completes. The command must be dropped: the arm bit and read bit must read 0, and no stall may follow.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_STALL = 2'd1,
        ST_WR_STALL = 2'd2,
        ST_WR_BUSY  = 2'd3
    } nvb_state_e;

    localparam int RD_STALL_CYC = 4;
    localparam int WR_STALL_CYC = 2;
    localparam int ARM_WIN_CYC  = 4;

    localparam logic [1:0] SEL_ADDR_LO = 2'd0;
    localparam logic [1:0] SEL_ADDR_HI = 2'd1;
    localparam logic [1:0] SEL_DATA    = 2'd2;
    localparam logic [1:0] SEL_CMD     = 2'd3;

    localparam int CB_RD  = 0;
    localparam int CB_WR  = 1;
    localparam int CB_ARM = 2;
    localparam int CB_IE  = 3;

endpackage

// File: rtl/nvb_arm.sv
module nvb_arm #(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_set_i,
    input  logic arm_clr_i,
    output logic arm_active_o
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (arm_clr_i) begin
            win_q <= '0;
        end else if (arm_set_i) begin
            win_q <= CW'(WIN);
        end else if (win_q != '0) begin
            win_q <= win_q - CW'(1);
        end
    end

    assign arm_active_o = (win_q != '0);

endmodule

// File: rtl/nvb_seq.sv
module nvb_seq
    import nvb_pkg::*;
#(
    parameter int WR_CYC = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_req_i,
    input  logic       wr_req_i,
    output nvb_state_e state_o,
    output logic       stall_o,
    output logic       rd_busy_o,
    output logic       wr_busy_o,
    output logic       rd_done_o,
    output logic       wr_done_o
);
    localparam int CW = $clog2(WR_CYC);

    nvb_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (wr_req_i) begin
                    st_d  = ST_WR_STALL;
                    cnt_d = CW'(WR_CYC - 1);
                end else if (rd_req_i) begin
                    st_d  = ST_RD_STALL;
                    cnt_d = CW'(RD_STALL_CYC - 1);
                end
            end
            ST_RD_STALL: begin
                if (cnt_q == '0) st_d = ST_IDLE;
                else             cnt_d = cnt_q - CW'(1);
            end
            ST_WR_STALL: begin
                cnt_d = cnt_q - CW'(1);
                if (cnt_q == CW'(WR_CYC - WR_STALL_CYC)) st_d = ST_WR_BUSY;
            end
            ST_WR_BUSY: begin
                if (cnt_q == '0) st_d = ST_IDLE;
                else             cnt_d = cnt_q - CW'(1);
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        state_o   = st_q;
        stall_o   = (st_q == ST_RD_STALL) || (st_q == ST_WR_STALL);
        rd_busy_o = (st_q == ST_RD_STALL);
        wr_busy_o = (st_q == ST_WR_STALL) || (st_q == ST_WR_BUSY);
        rd_done_o = (st_q == ST_RD_STALL) && (cnt_q == '0);
        wr_done_o = (st_q == ST_WR_BUSY) && (cnt_q == '0);
    end

    // R3: a write stall lasts two cycles
    a_r3_wr_stall_two: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy_o) |-> stall_o ##1 stall_o ##1 !stall_o);

    // R2: a read stall lasts four cycles
    a_r2_rd_stall_four: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_busy_o) |-> stall_o ##1 stall_o ##1 stall_o ##1 stall_o ##1 !stall_o);

endmodule

// File: rtl/nvb_store.sv
module nvb_store #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl
    import nvb_pkg::*;
#(
    parameter int ADDR_BITS = 9,
    parameter int WR_CYCLES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] io_sel,
    input  logic       io_we,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    output logic       cpu_stall,
    output logic       irq_ready
);
    localparam int HI_W = ADDR_BITS - 8;

    logic [ADDR_BITS-1:0] addr_q;
    logic [7:0]           data_q;
    logic                 ie_q;
    logic [7:0]           mem_rdata;

    nvb_state_e state;
    logic       idle, stall, rd_busy, wr_busy, rd_done, wr_done;
    logic       arm_active, cmd_wr, wr_req, rd_req, arm_set;

    assign idle    = (state == ST_IDLE);
    assign cmd_wr  = io_we && (io_sel == SEL_CMD);
    assign wr_req  = cmd_wr && idle && io_wdata[CB_WR] && arm_active;
    assign rd_req  = cmd_wr && idle && io_wdata[CB_RD] && !wr_req;
    assign arm_set = cmd_wr && idle && io_wdata[CB_ARM];

    nvb_arm #(.WIN(ARM_WIN_CYC)) u_arm (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_set_i    (arm_set),
        .arm_clr_i    (wr_req),
        .arm_active_o (arm_active)
    );

    nvb_seq #(.WR_CYC(WR_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req_i  (rd_req),
        .wr_req_i  (wr_req),
        .state_o   (state),
        .stall_o   (stall),
        .rd_busy_o (rd_busy),
        .wr_busy_o (wr_busy),
        .rd_done_o (rd_done),
        .wr_done_o (wr_done)
    );

    nvb_store #(.AW(ADDR_BITS), .DW(8)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_done),
        .addr_i  (addr_q),
        .wdata_i (data_q),
        .rdata_o (mem_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            ie_q   <= 1'b0;
        end else begin
            if (io_we && idle && io_sel == SEL_ADDR_LO)
                addr_q[7:0] <= io_wdata;
            if (io_we && idle && io_sel == SEL_ADDR_HI)
                addr_q[ADDR_BITS-1:8] <= io_wdata[HI_W-1:0];
            if (io_we && idle && io_sel == SEL_DATA)
                data_q <= io_wdata;
            else if (rd_done)
                data_q <= mem_rdata;
            if (cmd_wr)
                ie_q <= io_wdata[CB_IE];
        end
    end

    always_comb begin
        unique case (io_sel)
            SEL_ADDR_LO: io_rdata = addr_q[7:0];
            SEL_ADDR_HI: io_rdata = 8'(addr_q[ADDR_BITS-1:8]);
            SEL_DATA:    io_rdata = data_q;
            default:     io_rdata = 8'({ie_q, arm_active, wr_busy, rd_busy});
        endcase
    end

    assign cpu_stall = stall;
    assign irq_ready = ie_q && idle;

    // R5: the write machine only starts from an armed window
    a_r5_start_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> $past(arm_active));

    // R6: the address is frozen while an access is in progress
    a_r6_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_busy && $past(wr_busy)) |-> $stable(addr_q));

    // R8: the ready request never overlaps a stall or a busy write
    a_r8_irq_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ready |-> (!cpu_stall && !wr_busy));

    // R9: a combined start never leaves the read machine running
    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> !rd_busy);

endmodule

// File: tb/nvbyte_ctrl_tb.sv
module nvbyte_ctrl_tb;

    localparam int WRC = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] io_sel = 2'd0;
    logic       io_we = 1'b0;
    logic [7:0] io_wdata = 8'd0;
    logic [7:0] io_rdata;
    logic       cpu_stall;
    logic       irq_ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    nvbyte_ctrl #(.ADDR_BITS(9), .WR_CYCLES(WRC)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_sel    (io_sel),
        .io_we     (io_we),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .cpu_stall (cpu_stall),
        .irq_ready (irq_ready)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37) ^ (a >> 1) ^ 8'h5A);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [7:0] v);
        io_sel = s; io_wdata = v; io_we = 1'b1;
        @(negedge clk);
        io_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] s, output logic [7:0] v);
        io_sel = s;
        #1;
        v = io_rdata;
    endtask

    task automatic set_addr(input int a);
        wr_reg(2'd0, 8'(a));
        wr_reg(2'd1, 8'(a >> 8));
    endtask

    // count busy (bit1) cycles and stall cycles after an accepted start
    task automatic track_write(output int st, output int bz);
        logic [7:0] v;
        st = 0; bz = 0;
        for (int g = 0; g < 1000; g++) begin
            rd_reg(2'd3, v);
            if (!v[1]) break;
            bz++;
            if (cpu_stall) st++;
            @(negedge clk);
        end
    endtask

    task automatic do_write(input int a, input logic [7:0] d, output int st, output int bz);
        set_addr(a);
        wr_reg(2'd2, d);
        wr_reg(2'd3, 8'h04);
        wr_reg(2'd3, 8'h02);
        track_write(st, bz);
    endtask

    task automatic do_read(input int a, output logic [7:0] d, output int st, output int rb);
        logic [7:0] v;
        set_addr(a);
        wr_reg(2'd3, 8'h01);
        st = 0; rb = 0;
        for (int g = 0; g < 100; g++) begin
            rd_reg(2'd3, v);
            if (!v[0]) break;
            rb++;
            if (cpu_stall) st++;
            @(negedge clk);
        end
        rd_reg(2'd2, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int st, bz, rb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R10: reset contents of every slot
        for (int s = 0; s < 4; s++) begin
            rd_reg(2'(s), v);
            chk($sformatf("R1 R10 slot %0d after reset", s), v, 0);
        end
        chk("R1 stall after reset", cpu_stall, 0);
        chk("R1 irq after reset", irq_ready, 0);

        // R1 / R2: erased byte, read stall length
        do_read(9'h123, v, st, rb);
        chk("R1 erased byte", v, 8'hFF);
        chk("R2 read stall cycles", st, 4);
        chk("R2 read bit cycles", rb, 4);
        rd_reg(2'd3, v);
        chk("R2 read bit cleared", v[0], 0);

        // R5: start without arming
        set_addr(5);
        wr_reg(2'd2, 8'h33);
        wr_reg(2'd3, 8'h02);
        rd_reg(2'd3, v);
        chk("R5 unarmed start ignored", v[1], 0);
        // R5: arm and start in one write
        wr_reg(2'd3, 8'h06);
        rd_reg(2'd3, v);
        chk("R5 same-write start ignored", v[1], 0);
        chk("R5 arm bit set", v[2], 1);
        repeat (4) @(negedge clk);
        rd_reg(2'd3, v);
        chk("R5 arm expires after 4 cycles", v[2], 0);
        do_read(5, v, st, rb);
        chk("R5 byte unchanged", v, 8'hFF);

        // R5: window sweep, start 1..7 edges after the arming edge
        for (int n = 0; n < 7; n++) begin
            set_addr(9'h40 + n);
            wr_reg(2'd2, 8'(8'h10 + n));
            wr_reg(2'd3, 8'h04);
            repeat (n) @(negedge clk);
            wr_reg(2'd3, 8'h02);
            rd_reg(2'd3, v);
            chk($sformatf("R5 window gap %0d busy", n), v[1], (n <= 3) ? 1 : 0);
            chk($sformatf("R5 window gap %0d arm cleared", n), v[2], 0);
            track_write(st, bz);
            do_read(9'h40 + n, v, st, rb);
            chk($sformatf("R5 window gap %0d byte", n), v, (n <= 3) ? (8'h10 + n) : 8'hFF);
        end

        // R3 / R4: full sweep of writes
        for (int a = 0; a < 512; a++) begin
            do_write(a, pat(a), st, bz);
            chk($sformatf("R3 write stall @%0d", a), st, 2);
            chk($sformatf("R4 busy cycles @%0d", a), bz, WRC);
        end
        for (int a = 0; a < 512; a++) begin
            do_read(a, v, st, rb);
            chk($sformatf("R4 R2 readback @%0d", a), v, pat(a));
        end

        // R6: register changes while busy are dropped
        set_addr(10);
        wr_reg(2'd2, 8'hAA);
        wr_reg(2'd3, 8'h04);
        wr_reg(2'd3, 8'h02);
        repeat (3) @(negedge clk);
        wr_reg(2'd0, 8'h77);
        wr_reg(2'd1, 8'h01);
        wr_reg(2'd2, 8'h55);
        wr_reg(2'd3, 8'h05);
        rd_reg(2'd0, v);  chk("R6 addr low frozen", v, 10);
        rd_reg(2'd1, v);  chk("R6 addr high frozen", v, 0);
        rd_reg(2'd2, v);  chk("R6 data frozen", v, 8'hAA);
        rd_reg(2'd3, v);
        chk("R6 read bit ignored", v[0], 0);
        chk("R6 arm ignored", v[2], 0);
        chk("R6 no stall", cpu_stall, 0);
        track_write(st, bz);
        do_read(10, v, st, rb);
        chk("R6 byte written", v, 8'hAA);

        // R6: command on the completing edge of a write
        set_addr(11);
        wr_reg(2'd2, 8'h3C);
        wr_reg(2'd3, 8'h04);
        wr_reg(2'd3, 8'h02);
        repeat (WRC - 1) @(negedge clk);
        rd_reg(2'd3, v);
        chk("R4 last busy cycle", v[1], 1);
        wr_reg(2'd3, 8'h05);
        rd_reg(2'd3, v);
        chk("R6 completing-edge busy done", v[1], 0);
        chk("R6 completing-edge arm dropped", v[2], 0);
        chk("R6 completing-edge read dropped", v[0], 0);
        chk("R6 completing-edge no stall", cpu_stall, 0);
        do_read(11, v, st, rb);
        chk("R4 completing-edge byte", v, 8'h3C);

        // R9: read and write bits together
        set_addr(12);
        wr_reg(2'd2, 8'hC3);
        wr_reg(2'd3, 8'h04);
        wr_reg(2'd3, 8'h03);
        rd_reg(2'd3, v);
        chk("R9 write started", v[1], 1);
        chk("R9 read not started", v[0], 0);
        track_write(st, bz);
        chk("R9 busy cycles", bz, WRC);
        do_read(12, v, st, rb);
        chk("R9 byte", v, 8'hC3);

        // R7: upper address bits
        wr_reg(2'd1, 8'hFF);
        rd_reg(2'd1, v);
        chk("R7 high slot masked", v, 1);
        set_addr(9'h0FF);
        wr_reg(2'd1, 8'hFE);
        wr_reg(2'd3, 8'h01);
        repeat (4) @(negedge clk);
        rd_reg(2'd2, v);
        chk("R7 upper bits ignored", v, pat(9'h0FF));

        // R8: ready interrupt
        wr_reg(2'd3, 8'h08);
        chk("R8 irq idle enabled", irq_ready, 1);
        set_addr(13);
        wr_reg(2'd3, 8'h0C);
        wr_reg(2'd3, 8'h0A);
        chk("R8 irq low while busy", irq_ready, 0);
        track_write(st, bz);
        chk("R8 irq back after write", irq_ready, 1);
        wr_reg(2'd3, 8'h09);
        chk("R8 irq low during read stall", irq_ready, 0);
        repeat (4) @(negedge clk);
        chk("R8 irq after read", irq_ready, 1);
        wr_reg(2'd3, 8'h00);
        chk("R8 irq disabled", irq_ready, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule